// File: doc/BRIEF.md
# Ethernet Receive Frame Qualifier

This block sits behind a media-independent receive front end that has already stripped preamble and start delimiter. It watches the frame bytes go by, one per valid beat, and keeps three running results: a byte count, a reflected CRC-32 register and a sticky flag for PHY receive errors. On the beat that carries the end marker it also samples how many stray bits followed the last whole byte. From these it forms a five-bit status word and a keep/drop verdict, which a downstream receive FIFO uses to commit or discard the frame.

Input is a valid-qualified stream with no back-pressure. The front end cannot pause a frame on the wire, so the block takes every valid beat and has no ready output. A beat counts only when `in_valid` is high. A frame opens on a beat with `in_sof` and closes on a beat with `in_eof`, and both may fall on the same beat. Two plain control inputs let frames that are too long or too short be kept anyway. Any other disqualifying condition drops the frame at once.

Top module: `eth_rx_qual`

## Requirements
- R1: During and right after reset, `st_valid`, `st_accept`, `st_flush` and `st_word` are all 0.
- R2: `st_valid` is high for exactly one cycle, the cycle after the clock edge that takes the end-of-frame beat. In that cycle exactly one of `st_accept` and `st_flush` is high. Outside that cycle all three outputs and `st_word` are 0. The layout of `st_word` is: bit 4 CRC error, bit 3 dribble, bit 2 code violation, bit 1 too long, bit 0 too short.
- R3: The CRC-32 is reflected, uses polynomial 0x04C11DB7 and starts from 0xFFFFFFFF. It runs over every byte of the frame, FCS included. When the register ends at 0xDEBB20E3, `st_word[4]` is 0. Any other ending value sets it and forces `st_flush`.
- R4: If `in_rxerr` is high on any counted beat of the frame, `st_word[2]` is set and the frame is flushed.
- R5: A nonzero `in_extra_bits` (1 to 7) on the end beat sets `st_word[3]`. A frame whose only flag is dribble is accepted.
- R6: A frame shorter than 64 bytes sets `st_word[0]`. It is flushed when `cfg_keep_short` is 0 and accepted when it is 1, provided there is no other error.
- R7: A frame longer than 1518 bytes sets `st_word[1]`. It is flushed when `cfg_keep_long` is 0 and accepted when it is 1, provided there is no other error.
- R8: Frames of exactly 64 and exactly 1518 bytes set neither length flag. Frames of 63 and 1519 bytes set the short and long flag respectively.
- R9: The length counter saturates at 2^LEN_W-1. A frame longer than that still reports too long and never too short.
- R10: Every start marker clears length, CRC and error state. Back-to-back frames, and a frame that restarts before its end marker, are each judged only on the bytes since the latest start marker.
- R11: Beats with `in_valid` low are ignored. Valid beats outside a frame are ignored, including an end marker with no open frame, and they produce no status pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier for the byte stream |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last whole byte of a frame |
| in_rxerr | input | 1 | PHY receive error for this beat |
| in_extra_bits | input | 3 | Bits received after the last whole byte, sampled on the end beat |
| cfg_keep_long | input | 1 | Keep frames that are too long |
| cfg_keep_short | input | 1 | Keep frames that are too short |
| st_valid | output | 1 | One-cycle frame verdict strobe |
| st_word | output | 5 | Frame status flags (layout in R2) |
| st_accept | output | 1 | Commit the frame |
| st_flush | output | 1 | Discard the frame |

## Verification
Frames carrying a correct FCS are compared against the same frames with one corrupted byte, which separates the CRC residue test from the length and error paths. Sizes on both sides of 64 and 1518 bytes, each run with its keep control off and on, show whether the comparison boundaries are right and whether each keep control acts only on its own flag. A frame longer than the counter range would let a wrapping counter report it as short. Back-to-back frames, a frame aborted by a fresh start marker, stray beats outside a frame and frames with idle gaps show whether state clears at the right moment and whether beats are qualified correctly.

// File: rtl/eth_rxq_pkg.sv
package eth_rxq_pkg;

  localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_RF = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  typedef struct packed {
    logic crc_bad;
    logic dribble;
    logic code_viol;
    logic too_long;
    logic too_short;
  } rxq_status_t;

  function automatic logic [31:0] crc_step(input logic [31:0] cur, input logic [7:0] b);
    logic [31:0] c;
    c = cur ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_RF) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxq_crc.sv
module rxq_crc
  import eth_rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        sof,
  input  logic [7:0]  data,
  output logic [31:0] crc_next
);
  logic [31:0] crc_q;

  always_comb crc_next = crc_step(sof ? CRC_SEED : crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (beat) crc_q <= crc_next;
  end
endmodule

// File: rtl/rxq_len.sv
module rxq_len #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  output logic [LEN_W-1:0] len_next
);
  localparam logic [LEN_W-1:0] LEN_TOP = {LEN_W{1'b1}};
  logic [LEN_W-1:0] len_q;

  always_comb begin
    if (sof)                  len_next = LEN_W'(1);
    else if (len_q == LEN_TOP) len_next = LEN_TOP;
    else                      len_next = len_q + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    len_q <= '0;
    else if (beat) len_q <= len_next;
  end

  // R9: once saturated, further bytes of the same frame keep the count pinned
  p_len_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && len_q == LEN_TOP) |=> (len_q == LEN_TOP));
endmodule

// File: rtl/rxq_err.sv
module rxq_err (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic sof,
  input  logic rxerr,
  output logic cv_next
);
  logic cv_q;

  always_comb cv_next = (cv_q & ~sof) | rxerr;

  always_ff @(posedge clk) begin
    if (!rst_n)    cv_q <= 1'b0;
    else if (beat) cv_q <= cv_next;
  end

  // R4: a PHY error on a counted beat is remembered for the frame
  p_cv_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && rxerr) |=> cv_q);
endmodule

// File: rtl/eth_rx_qual.sv
module eth_rx_qual
  import eth_rxq_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_rxerr,
  input  logic [2:0] in_extra_bits,
  input  logic       cfg_keep_long,
  input  logic       cfg_keep_short,
  output logic       st_valid,
  output logic [4:0] st_word,
  output logic       st_accept,
  output logic       st_flush
);
  localparam logic [LEN_W-1:0] LIM_LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LIM_HI = LEN_W'(MAX_LEN);

  logic             in_frame_q;
  logic             beat, end_beat;
  logic [31:0]      crc_next;
  logic [LEN_W-1:0] len_next;
  logic             cv_next;
  rxq_status_t      verdict;
  logic             drop;

  assign beat     = in_valid & (in_sof | in_frame_q);
  assign end_beat = beat & in_eof;

  rxq_crc u_crc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .data(in_data), .crc_next(crc_next)
  );

  rxq_len #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .len_next(len_next)
  );

  rxq_err u_err (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .rxerr(in_rxerr), .cv_next(cv_next)
  );

  always_comb begin
    verdict.crc_bad   = (crc_next != CRC_RESIDUE);
    verdict.dribble   = (in_extra_bits != 3'd0);
    verdict.code_viol = cv_next;
    verdict.too_long  = (len_next > LIM_HI);
    verdict.too_short = (len_next < LIM_LO);
    drop = verdict.crc_bad | verdict.code_viol
         | (verdict.too_long  & ~cfg_keep_long)
         | (verdict.too_short & ~cfg_keep_short);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      st_valid   <= 1'b0;
      st_word    <= '0;
      st_accept  <= 1'b0;
      st_flush   <= 1'b0;
    end else begin
      if (beat) in_frame_q <= ~in_eof;
      st_valid  <= end_beat;
      st_word   <= end_beat ? verdict : '0;
      st_accept <= end_beat & ~drop;
      st_flush  <= end_beat &  drop;
    end
  end

  // R2: the end beat of an open frame yields a strobe on the next cycle
  p_strobe_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && (in_sof || in_frame_q)) |=> st_valid);
  // R2: exactly one outcome while strobing, none otherwise
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_accept != st_flush));
  p_quiet_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> (!st_accept && !st_flush && st_word == 5'd0));
  // R3: a CRC failure always discards
  p_crc_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_word[4]) |-> st_flush);
  // R5: dribble alone never discards
  p_dribble_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_word == 5'b01000) |-> st_accept);
endmodule

// File: tb/sim_eth_rx_qual.sv
module sim_eth_rx_qual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_sof = 1'b0, in_eof = 1'b0, in_rxerr = 1'b0;
  logic [2:0] in_extra_bits = 3'd0;
  logic       cfg_keep_long = 1'b0, cfg_keep_short = 1'b0;
  logic       st_valid, st_accept, st_flush;
  logic [4:0] st_word;

  int n_run = 0, n_fail = 0;
  logic [7:0] fb [0:2199];

  always #10 clk = ~clk;

  eth_rx_qual u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_rxerr(in_rxerr),
    .in_extra_bits(in_extra_bits), .cfg_keep_long(cfg_keep_long),
    .cfg_keep_short(cfg_keep_short), .st_valid(st_valid), .st_word(st_word),
    .st_accept(st_accept), .st_flush(st_flush)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb_bit;
        fb_bit = r[0] ^ fb[i][b];
        r = r >> 1;
        if (fb_bit) r = r ^ 32'hEDB8_8320;
      end
    end
    return r;
  endfunction

  task automatic build(input int n, input bit bad);
    logic [31:0] c;
    for (int i = 0; i < n - 4; i++) fb[i] = 8'((i * 7 + n) & 255);
    c = ~ref_crc(n - 4);
    for (int i = 0; i < 4; i++) fb[n - 4 + i] = c[8*i +: 8];
    if (bad) fb[0] = fb[0] ^ 8'h5A;
  endtask

  task automatic idle();
    in_valid = 0; in_sof = 0; in_eof = 0; in_rxerr = 0; in_extra_bits = 0;
  endtask

  // drives a frame; outputs are sampled at the negedge after the end beat
  task automatic drive(input int n, input int err_at, input int extra,
                       input bit gaps, input bit no_end);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 5 == 2)) begin
        idle(); in_data = 8'hEE; in_rxerr = 1;
        @(negedge clk);
      end
      in_valid = 1; in_data = fb[i];
      in_sof = (i == 0); in_eof = (i == n - 1) && !no_end;
      in_rxerr = (i == err_at);
      in_extra_bits = in_eof ? 3'(extra) : 3'd0;
      @(negedge clk);
    end
    idle();
  endtask

  task automatic frame(input string req, input int n, input bit bad, input int err_at,
                       input int extra, input bit gaps);
    logic [4:0] ew;
    bit drop;
    build(n, bad);
    drive(n, err_at, extra, gaps, 1'b0);
    ew = {bad, extra != 0, err_at >= 0, n > 1518, n < 64};
    drop = bad || (err_at >= 0) || (n > 1518 && !cfg_keep_long) || (n < 64 && !cfg_keep_short);
    chk(st_valid == 1'b1, {req, " strobe"}, st_valid, 1);
    chk(st_word == ew, {req, " word"}, st_word, ew);
    chk(st_accept == !drop && st_flush == drop, {req, " outcome"},
        {st_accept, st_flush}, {!drop, drop});
    @(negedge clk);
    chk(st_valid == 0 && st_word == 0, {req, " single-cycle R2"}, st_valid, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(st_valid == 0 && st_accept == 0 && st_flush == 0 && st_word == 0,
        "R1 reset outputs", {st_valid, st_accept, st_flush, st_word}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(st_valid == 0 && st_word == 0, "R1 after release", st_valid, 0);
  endtask

  task automatic t_crc();
    frame("R2 R3 good", 100, 0, -1, 0, 0);
    frame("R3 bad fcs", 100, 1, -1, 0, 0);
  endtask

  task automatic t_cv();
    frame("R4 rxerr mid", 120, 0, 30, 0, 0);
    frame("R4 rxerr last", 80, 0, 79, 0, 0);
  endtask

  task automatic t_dribble();
    frame("R5 dribble ok", 90, 0, -1, 3, 0);
    frame("R5 dribble bad crc", 90, 1, -1, 7, 0);
  endtask

  task automatic t_short();
    cfg_keep_short = 0; frame("R6 short drop", 40, 0, -1, 0, 0);
    cfg_keep_short = 1; frame("R6 short keep", 40, 0, -1, 0, 0);
    cfg_keep_short = 0;
  endtask

  task automatic t_long();
    cfg_keep_long = 0; frame("R7 long drop", 1600, 0, -1, 0, 0);
    cfg_keep_long = 1; frame("R7 long keep", 1600, 0, -1, 0, 0);
    cfg_keep_long = 0;
  endtask

  task automatic t_bounds();
    frame("R8 64", 64, 0, -1, 0, 0);
    frame("R8 1518", 1518, 0, -1, 0, 0);
    frame("R8 63", 63, 0, -1, 0, 0);
    frame("R8 1519", 1519, 0, -1, 0, 0);
  endtask

  task automatic t_saturate();
    cfg_keep_long = 1; frame("R9 past counter range", 2100, 0, -1, 0, 0);
    cfg_keep_long = 0;
  endtask

  task automatic t_restart();
    // bad frame then a good one with no idle cycle in between
    build(70, 1);
    for (int i = 0; i < 70; i++) begin
      in_valid = 1; in_data = fb[i]; in_sof = (i == 0); in_eof = (i == 69);
      in_rxerr = (i == 10); in_extra_bits = 0;
      @(negedge clk);
    end
    chk(st_valid && st_word == 5'b10100, "R10 first of pair", st_word, 5'b10100);
    frame("R10 second of pair", 70, 0, -1, 0, 0);
    // aborted frame (no end marker, with error), then restart
    build(30, 0);
    drive(30, 5, 0, 0, 1'b1);
    chk(st_valid == 0, "R10 no strobe on abort", st_valid, 0);
    frame("R10 after abort", 72, 0, -1, 0, 0);
  endtask

  task automatic t_stray();
    int seen = 0;
    for (int i = 0; i < 12; i++) begin
      in_valid = 1; in_data = 8'(i * 13); in_sof = 0;
      in_eof = (i % 4 == 3); in_rxerr = 1;
      @(negedge clk);
      if (st_valid) seen++;
    end
    idle();
    @(negedge clk);
    if (st_valid) seen++;
    chk(seen == 0, "R11 stray beats ignored", seen, 0);
    frame("R11 gaps ignored", 96, 0, -1, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    @(negedge clk);
    t_reset();
    t_crc();
    t_cv();
    t_dribble();
    t_short();
    t_long();
    t_bounds();
    t_saturate();
    t_restart();
    t_stray();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule